// File: doc/BRIEF.md
# Audio Codec Clock Divider Tree

This block produces all the clock enables that an audio codec's digital logic needs, starting from a single master clock. The block runs entirely in the master clock domain. It first forms a system tick, which is either every master cycle or every second one. That tick feeds a set of independent programmable dividers:

- a general-purpose tick, nominally 256 kHz;
- an ADC tick, with an optional extra divide-by-3 stage for 384fs operation;
- a DAC tick;
- a DC-servo tick;
- a class-D switching tick;
- a slow timeout tick for volume updates, made by a fixed /64 and /16 prescaler followed by a programmable stage.

Every branch output is a single-cycle strobe, to be used as a clock enable downstream. When the block is bus master, it also drives a square-wave bit clock and a left/right frame clock. The frame clock is counted in bit-clock periods.

Each programmable field with value N divides its input tick by N+1, so 0 means pass-through. Each counter latches its ratio when it reaches terminal count. A ratio change written in mid-count therefore only takes hold after the current period ends. A synchronous active-low reset clears all counters. As a result, every branch fires its first strobe exactly one output period after reset is released. Ratios are static configuration inputs.

Top module: `codec_clk_tree`

## Requirements
- R1: With `sys_half_i`=0 the system tick `sys_stb_o` is high in every cycle while enabled. With `sys_half_i`=1 it is high in every second cycle, first in the 2nd cycle after reset is released.
- R2: While `sys_en_i` is low, no strobe output is high, and `bclk_o` and `lrclk_o` do not change.
- R3: While `dsp_en_i` is low, `adc_stb_o` and `dac_stb_o` stay low. The other branches keep running.
- R4: A programmable divider with field value N gives one strobe per N+1 system ticks. N=0 passes the system tick through in the same cycle. The first strobe comes on the (N+1)-th system tick after reset.
- R5: A ratio change made while a divider is counting takes effect only after that divider's next strobe.
- R6: With `adc_hi_i`=1 the ADC strobe is the ADC divider output divided by a further 3.
- R7: The timeout strobe comes once every 64×16×(N+1) system ticks while `to_en_i` is high. While `to_en_i` is low it never fires and its counters are cleared.
- R8: In master mode, `bclk_o` starts low and toggles on every bit-clock divider strobe. With field value N it rises after N+1 system ticks and has a period of 2(N+1) ticks.
- R9: The frame length is F+1 bit-clock periods, where F is the 9-bit field and F=0 is treated as 1. `lrclk_o` is high for the first ceil(length/2) periods of each frame. It changes only on a falling `bclk_o` edge, and goes high at the first falling edge after reset.
- R10: With `master_i`=0, `bclk_o` and `lrclk_o` are low and their counters are held cleared. On entry to master mode the bit clock starts afresh.
- R11: While `rst_n` is low every strobe is low, and `bclk_o` and `lrclk_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst_n | input | 1 | synchronous active-low reset |
| sys_half_i | input | 1 | 1: system tick is master clock / 2 |
| sys_en_i | input | 1 | system clock enable |
| dsp_en_i | input | 1 | enable for ADC and DAC branches |
| master_i | input | 1 | 1: generate bit and frame clocks |
| adc_hi_i | input | 1 | 1: 384fs mode, extra ADC divide by 3 |
| to_en_i | input | 1 | timeout tick enable |
| gp_div_i | input | 6 | general-purpose divider field |
| adc_div_i | input | 3 | ADC divider field |
| dac_div_i | input | 3 | DAC divider field |
| srv_div_i | input | 4 | DC-servo divider field |
| cld_div_i | input | 3 | class-D divider field |
| bck_div_i | input | 4 | bit-clock divider field |
| frm_div_i | input | 9 | frame length field, in bit-clock periods |
| to_div_i | input | 4 | timeout final-stage field |
| sys_stb_o | output | 1 | system tick strobe |
| gp_stb_o | output | 1 | general-purpose strobe |
| adc_stb_o | output | 1 | ADC strobe |
| dac_stb_o | output | 1 | DAC strobe |
| srv_stb_o | output | 1 | DC-servo strobe |
| cld_stb_o | output | 1 | class-D strobe |
| to_stb_o | output | 1 | timeout strobe |
| bclk_o | output | 1 | bit clock |
| lrclk_o | output | 1 | frame clock |

## Verification
Each branch is run from reset under several combinations of system-tick halving and field value, including 0, the field maximum and the 256 kHz setting. Checking the first strobe position as well as the spacing between strobes separates an off-by-one reload from a counter that does not reset properly. A ratio rewritten in mid-count shows whether the terminal-count latch is present. Odd, even and zero frame lengths show the duty split, the clamp, and the alignment to the falling bit-clock edge. Gating tests and the slave-to-master transition show that disabled branches stay silent and restart from a cleared state.

// File: rtl/codec_clk_pkg.sv
package codec_clk_pkg;
  // effective frame field: a zero-length frame is widened to two periods
  function automatic int unsigned frame_last(int unsigned f);
    return (f == 0) ? 1 : f;
  endfunction

  // number of high bit-clock periods for a frame whose last index is f
  function automatic int unsigned frame_high(int unsigned f);
    return (f + 2) / 2;
  endfunction
endpackage

// File: rtl/ccd_div.sv
module ccd_div #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         tick_i,
  input  logic [W-1:0] ratio_i,
  output logic         stb_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] lim_q;
  logic         at_end;

  assign at_end = (cnt_q == lim_q);
  assign stb_o  = tick_i & at_end;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      cnt_q <= '0;
      lim_q <= ratio_i;
    end else if (tick_i) begin
      if (at_end) begin
        cnt_q <= '0;
        lim_q <= ratio_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ccd_frame.sv
module ccd_frame
  import codec_clk_pkg::*;
#(
  parameter int FW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          bstb_i,
  input  logic [FW-1:0] frm_i,
  output logic          bclk_o,
  output logic          lrclk_o,
  output logic          fall_o,
  output logic          wrap_o
);
  logic          bclk_q;
  logic          lr_q;
  logic [FW-1:0] fcnt_q;
  logic [FW-1:0] flim_q;
  logic [FW-1:0] hlen_q;
  logic [FW-1:0] f_eff;
  logic [FW-1:0] h_eff;
  logic [FW-1:0] fcnt_nx;

  assign f_eff   = FW'(frame_last(32'(frm_i)));
  assign h_eff   = FW'(frame_high(32'(f_eff)));
  assign fcnt_nx = fcnt_q + 1'b1;
  assign fall_o  = bstb_i & bclk_q;
  assign wrap_o  = fall_o & (fcnt_q == flim_q);
  assign bclk_o  = bclk_q;
  assign lrclk_o = lr_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      bclk_q <= 1'b0;
      lr_q   <= 1'b0;
      fcnt_q <= f_eff;
      flim_q <= f_eff;
      hlen_q <= h_eff;
    end else begin
      if (bstb_i) bclk_q <= ~bclk_q;
      if (wrap_o) begin
        fcnt_q <= '0;
        flim_q <= f_eff;
        hlen_q <= h_eff;
        lr_q   <= 1'b1;
      end else if (fall_o) begin
        fcnt_q <= fcnt_nx;
        lr_q   <= (fcnt_nx < hlen_q);
      end
    end
  end
endmodule

// File: rtl/codec_clk_tree.sv
module codec_clk_tree
  import codec_clk_pkg::*;
#(
  parameter int GP_W     = 6,
  parameter int ADC_W    = 3,
  parameter int DAC_W    = 3,
  parameter int SRV_W    = 4,
  parameter int CLD_W    = 3,
  parameter int BCK_W    = 4,
  parameter int FRM_W    = 9,
  parameter int TO_W     = 4,
  parameter int TO_PRE_A = 64,
  parameter int TO_PRE_B = 16,
  parameter int ADC_TRI  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sys_half_i,
  input  logic             sys_en_i,
  input  logic             dsp_en_i,
  input  logic             master_i,
  input  logic             adc_hi_i,
  input  logic             to_en_i,
  input  logic [GP_W-1:0]  gp_div_i,
  input  logic [ADC_W-1:0] adc_div_i,
  input  logic [DAC_W-1:0] dac_div_i,
  input  logic [SRV_W-1:0] srv_div_i,
  input  logic [CLD_W-1:0] cld_div_i,
  input  logic [BCK_W-1:0] bck_div_i,
  input  logic [FRM_W-1:0] frm_div_i,
  input  logic [TO_W-1:0]  to_div_i,
  output logic             sys_stb_o,
  output logic             gp_stb_o,
  output logic             adc_stb_o,
  output logic             dac_stb_o,
  output logic             srv_stb_o,
  output logic             cld_stb_o,
  output logic             to_stb_o,
  output logic             bclk_o,
  output logic             lrclk_o
);
  localparam int PA_W = $clog2(TO_PRE_A);
  localparam int PB_W = $clog2(TO_PRE_B);
  localparam logic [PA_W-1:0] PA_LAST = PA_W'(TO_PRE_A - 1);
  localparam logic [PB_W-1:0] PB_LAST = PB_W'(TO_PRE_B - 1);

  logic sys_tick, dsp_tick, adc_base;
  logic to_tick, to_a, to_b;
  logic bck_stb, bclk_fall, frame_wrap;

  // system tick: pass-through or halve
  ccd_div #(.W(1)) u_sys (
    .clk(clk), .rst_n(rst_n), .clr_i(1'b0), .tick_i(sys_en_i & rst_n),
    .ratio_i(sys_half_i), .stb_o(sys_tick));

  assign sys_stb_o = sys_tick;
  assign dsp_tick  = sys_tick & dsp_en_i;
  assign to_tick   = sys_tick & to_en_i;

  ccd_div #(.W(GP_W)) u_gp (
    .clk(clk), .rst_n(rst_n), .clr_i(1'b0), .tick_i(sys_tick),
    .ratio_i(gp_div_i), .stb_o(gp_stb_o));

  ccd_div #(.W(ADC_W)) u_adc (
    .clk(clk), .rst_n(rst_n), .clr_i(1'b0), .tick_i(dsp_tick),
    .ratio_i(adc_div_i), .stb_o(adc_base));

  generate
    if (ADC_TRI > 1) begin : g_tri
      localparam int TRI_W = $clog2(ADC_TRI);
      logic adc_tri;
      ccd_div #(.W(TRI_W)) u_tri (
        .clk(clk), .rst_n(rst_n), .clr_i(~adc_hi_i), .tick_i(adc_base & adc_hi_i),
        .ratio_i(TRI_W'(ADC_TRI - 1)), .stb_o(adc_tri));
      assign adc_stb_o = adc_hi_i ? adc_tri : adc_base;
    end else begin : g_notri
      assign adc_stb_o = adc_base;
    end
  endgenerate

  ccd_div #(.W(DAC_W)) u_dac (
    .clk(clk), .rst_n(rst_n), .clr_i(1'b0), .tick_i(dsp_tick),
    .ratio_i(dac_div_i), .stb_o(dac_stb_o));

  ccd_div #(.W(SRV_W)) u_srv (
    .clk(clk), .rst_n(rst_n), .clr_i(1'b0), .tick_i(sys_tick),
    .ratio_i(srv_div_i), .stb_o(srv_stb_o));

  ccd_div #(.W(CLD_W)) u_cld (
    .clk(clk), .rst_n(rst_n), .clr_i(1'b0), .tick_i(sys_tick),
    .ratio_i(cld_div_i), .stb_o(cld_stb_o));

  // timeout: fixed prescale A, fixed prescale B, programmable stage
  ccd_div #(.W(PA_W)) u_to_a (
    .clk(clk), .rst_n(rst_n), .clr_i(~to_en_i), .tick_i(to_tick),
    .ratio_i(PA_LAST), .stb_o(to_a));

  ccd_div #(.W(PB_W)) u_to_b (
    .clk(clk), .rst_n(rst_n), .clr_i(~to_en_i), .tick_i(to_a),
    .ratio_i(PB_LAST), .stb_o(to_b));

  ccd_div #(.W(TO_W)) u_to_c (
    .clk(clk), .rst_n(rst_n), .clr_i(~to_en_i), .tick_i(to_b),
    .ratio_i(to_div_i), .stb_o(to_stb_o));

  // bit clock half-period divider and frame clock
  ccd_div #(.W(BCK_W)) u_bck (
    .clk(clk), .rst_n(rst_n), .clr_i(~master_i), .tick_i(sys_tick & master_i),
    .ratio_i(bck_div_i), .stb_o(bck_stb));

  ccd_frame #(.FW(FRM_W)) u_frm (
    .clk(clk), .rst_n(rst_n), .clr_i(~master_i), .bstb_i(bck_stb),
    .frm_i(frm_div_i), .bclk_o(bclk_o), .lrclk_o(lrclk_o),
    .fall_o(bclk_fall), .wrap_o(frame_wrap));
endmodule

// File: rtl/ccd_chk.sv
module ccd_chk (
  input logic clk,
  input logic rst_n,
  input logic sys_en,
  input logic dsp_en,
  input logic master,
  input logic to_en,
  input logic sys_stb,
  input logic gp_stb,
  input logic adc_stb,
  input logic dac_stb,
  input logic srv_stb,
  input logic cld_stb,
  input logic to_stb,
  input logic bclk,
  input logic lrclk,
  input logic bck_stb,
  input logic bclk_fall
);
  logic any_stb;
  assign any_stb = sys_stb | gp_stb | adc_stb | dac_stb | srv_stb | cld_stb | to_stb;

  AST_RESET_SILENT: assert property (@(posedge clk) !rst_n |-> !any_stb); // R11

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_en |-> !any_stb); // R2

  AST_DSP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !dsp_en |-> !(adc_stb || dac_stb)); // R3

  AST_TO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !to_en |-> !to_stb); // R7

  AST_SLAVE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !master |=> (!bclk && !lrclk)); // R10

  AST_BCLK_PACE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bclk) |-> ($past(bck_stb) || $past(!master))); // R8

  AST_LR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lrclk) |-> ($past(bclk_fall) || $past(!master))); // R9
endmodule

bind codec_clk_tree ccd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sys_en(sys_en_i), .dsp_en(dsp_en_i),
  .master(master_i), .to_en(to_en_i), .sys_stb(sys_stb_o), .gp_stb(gp_stb_o),
  .adc_stb(adc_stb_o), .dac_stb(dac_stb_o), .srv_stb(srv_stb_o),
  .cld_stb(cld_stb_o), .to_stb(to_stb_o), .bclk(bclk_o), .lrclk(lrclk_o),
  .bck_stb(bck_stb), .bclk_fall(bclk_fall));

// File: tb/sim_codec_clk_tree.sv
module sim_codec_clk_tree;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sys_half, sys_en, dsp_en, master, adc_hi, to_en;
  logic [5:0] gp_div;
  logic [2:0] adc_div, dac_div, cld_div;
  logic [3:0] srv_div, bck_div, to_div;
  logic [8:0] frm_div;
  logic sys_stb, gp_stb, adc_stb, dac_stb, srv_stb, cld_stb, to_stb, bclk, lrclk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic lr_log [0:15];
  logic bc_log [0:15];

  always #10 clk = ~clk;

  codec_clk_tree u0 (
    .clk(clk), .rst_n(rst_n), .sys_half_i(sys_half), .sys_en_i(sys_en),
    .dsp_en_i(dsp_en), .master_i(master), .adc_hi_i(adc_hi), .to_en_i(to_en),
    .gp_div_i(gp_div), .adc_div_i(adc_div), .dac_div_i(dac_div),
    .srv_div_i(srv_div), .cld_div_i(cld_div), .bck_div_i(bck_div),
    .frm_div_i(frm_div), .to_div_i(to_div), .sys_stb_o(sys_stb),
    .gp_stb_o(gp_stb), .adc_stb_o(adc_stb), .dac_stb_o(dac_stb),
    .srv_stb_o(srv_stb), .cld_stb_o(cld_stb), .to_stb_o(to_stb),
    .bclk_o(bclk), .lrclk_o(lrclk));

  // sel: 0 gp, 1 adc, 2 dac, 3 servo, 4 class-D, 5 adc in 384fs mode, 6 timeout, 7 system
  typedef struct packed { int sel; int half; int n; int p; } vec_t;
  localparam vec_t VEC [14] = '{
    '{0, 0, 47, 48}, '{0, 1, 5, 12}, '{0, 0, 0, 1},
    '{1, 0, 3, 4},   '{1, 1, 7, 16},
    '{2, 0, 0, 1},   '{2, 0, 6, 7},
    '{3, 0, 15, 16}, '{3, 1, 2, 6},
    '{4, 0, 7, 8},
    '{5, 0, 1, 6},   '{5, 1, 0, 6},
    '{7, 0, 0, 1},   '{7, 1, 0, 2}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic go();
    @(posedge clk);
    #6;
  endtask

  task automatic cfg_default();
    sys_half = 0; sys_en = 1; dsp_en = 1; master = 0; adc_hi = 0; to_en = 0;
    gp_div = 0; adc_div = 0; dac_div = 0; srv_div = 0; cld_div = 0;
    bck_div = 0; frm_div = 0; to_div = 0;
  endtask

  // after return, combinational outputs show window 1 after reset release
  task automatic do_reset();
    rst_n = 0;
    repeat (3) go();
    rst_n = 1;
    #1;
  endtask

  function automatic logic pick(input int sel);
    case (sel)
      0: return gp_stb;
      1: return adc_stb;
      2: return dac_stb;
      3: return srv_stb;
      4: return cld_stb;
      5: return adc_stb;
      6: return to_stb;
      default: return sys_stb;
    endcase
  endfunction

  task automatic measure(input int sel, input int limit, output int first, output int second);
    first = -1;
    second = -1;
    do_reset();
    for (int k = 1; k <= limit; k++) begin
      if (k > 1) go();
      if (pick(sel) === 1'b1) begin
        if (first < 0) first = k;
        else if (second < 0) second = k;
      end
    end
  endtask

  task automatic run_frame(input int fr, input int bdiv);
    cfg_default();
    master = 1;
    frm_div = 9'(fr);
    bck_div = 4'(bdiv);
    do_reset();
    for (int k = 1; k <= 15; k++) begin
      if (k > 1) go();
      lr_log[k] = lrclk;
      bc_log[k] = bclk;
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int f, s, cnt, c2;
    cfg_default();

    // R11: outputs quiet while reset is held, even with pass-through ratios
    master = 1;
    rst_n = 0;
    repeat (3) go();
    check({sys_stb, gp_stb, adc_stb, dac_stb, srv_stb, cld_stb, to_stb} == 7'd0,
          "R11 strobes in reset", int'({sys_stb, gp_stb, adc_stb, dac_stb}), 0);
    check(bclk == 1'b0 && lrclk == 1'b0, "R11 bclk/lrclk in reset",
          int'({bclk, lrclk}), 0);

    // R1 R4 R6: vector table, first strobe and spacing
    foreach (VEC[i]) begin
      cfg_default();
      sys_half = VEC[i].half[0];
      gp_div  = 6'(VEC[i].n);
      adc_div = 3'(VEC[i].n);
      dac_div = 3'(VEC[i].n);
      srv_div = 4'(VEC[i].n);
      cld_div = 3'(VEC[i].n);
      adc_hi  = (VEC[i].sel == 5);
      measure(VEC[i].sel, 2 * VEC[i].p + 4, f, s);
      check(f == VEC[i].p, (VEC[i].sel == 7) ? "R1 first tick" :
            (VEC[i].sel == 5) ? "R6 first strobe" : "R4 first strobe", f, VEC[i].p);
      check(s - f == VEC[i].p, (VEC[i].sel == 7) ? "R1 tick spacing" :
            (VEC[i].sel == 5) ? "R6 spacing" : "R4 spacing", s - f, VEC[i].p);
    end

    // R2: system enable low silences everything
    cfg_default();
    sys_en = 0; master = 1;
    do_reset();
    cnt = 0;
    for (int k = 1; k <= 40; k++) begin
      if (k > 1) go();
      cnt += int'(sys_stb | gp_stb | adc_stb | dac_stb | srv_stb | cld_stb | to_stb | bclk | lrclk);
    end
    check(cnt == 0, "R2 activity with sys_en low", cnt, 0);

    // R3: dsp enable low silences adc/dac only
    cfg_default();
    dsp_en = 0;
    do_reset();
    cnt = 0; c2 = 0;
    for (int k = 1; k <= 20; k++) begin
      if (k > 1) go();
      cnt += int'(adc_stb | dac_stb);
      c2 += int'(gp_stb);
    end
    check(cnt == 0, "R3 adc/dac strobes with dsp_en low", cnt, 0);
    check(c2 == 20, "R3 gp keeps running", c2, 20);

    // R5: ratio written mid-count applies after next strobe
    cfg_default();
    gp_div = 3;
    do_reset();
    cnt = 0;
    for (int k = 1; k <= 8; k++) begin
      if (k > 1) go();
      if (gp_stb) cnt += (1 << k);
      if (k == 1) gp_div = 1;
    end
    check(cnt == ((1 << 4) | (1 << 6) | (1 << 8)), "R5 strobe positions mask", cnt,
          (1 << 4) | (1 << 6) | (1 << 8));

    // R7: timeout chain
    cfg_default();
    to_en = 1; to_div = 1;
    measure(6, 4200, f, s);
    check(f == 2048, "R7 timeout first", f, 2048);
    check(s == 4096, "R7 timeout second", s, 4096);
    cfg_default();
    to_en = 0;
    do_reset();
    cnt = 0;
    for (int k = 1; k <= 1100; k++) begin
      if (k > 1) go();
      cnt += int'(to_stb);
    end
    check(cnt == 0, "R7 timeout with to_en low", cnt, 0);

    // R8: bit clock with field 2: high in windows 4..6, low 7..9, high 10
    run_frame(2, 2);
    check(bc_log[3] == 1'b0, "R8 bclk k3", int'(bc_log[3]), 0);
    check(bc_log[4] == 1'b1, "R8 bclk k4", int'(bc_log[4]), 1);
    check(bc_log[6] == 1'b1, "R8 bclk k6", int'(bc_log[6]), 1);
    check(bc_log[7] == 1'b0, "R8 bclk k7", int'(bc_log[7]), 0);
    check(bc_log[10] == 1'b1, "R8 bclk k10", int'(bc_log[10]), 1);

    // R9: frame field 2 (3 periods, 2 high), bit clock every tick
    run_frame(2, 0);
    check(bc_log[2] == 1'b1 && bc_log[3] == 1'b0, "R8 bclk pass-through", int'({bc_log[2], bc_log[3]}), 2);
    check(lr_log[2] == 1'b0, "R9 F2 k2", int'(lr_log[2]), 0);
    check(lr_log[3] == 1'b1, "R9 F2 k3", int'(lr_log[3]), 1);
    check(lr_log[6] == 1'b1, "R9 F2 k6", int'(lr_log[6]), 1);
    check(lr_log[7] == 1'b0, "R9 F2 k7", int'(lr_log[7]), 0);
    check(lr_log[8] == 1'b0, "R9 F2 k8", int'(lr_log[8]), 0);
    check(lr_log[9] == 1'b1, "R9 F2 k9", int'(lr_log[9]), 1);
    // R9: frame field 0 clamps to 1 (2 periods, 1 high)
    run_frame(0, 0);
    check(lr_log[3] == 1'b1, "R9 F0 k3", int'(lr_log[3]), 1);
    check(lr_log[5] == 1'b0, "R9 F0 k5", int'(lr_log[5]), 0);
    check(lr_log[7] == 1'b1, "R9 F0 k7", int'(lr_log[7]), 1);
    // R9: frame field 3 (4 periods, 2 high)
    run_frame(3, 0);
    check(lr_log[6] == 1'b1, "R9 F3 k6", int'(lr_log[6]), 1);
    check(lr_log[7] == 1'b0, "R9 F3 k7", int'(lr_log[7]), 0);
    check(lr_log[10] == 1'b0, "R9 F3 k10", int'(lr_log[10]), 0);
    check(lr_log[11] == 1'b1, "R9 F3 k11", int'(lr_log[11]), 1);

    // R10: slave mode holds clocks low; master entry restarts the bit clock
    cfg_default();
    bck_div = 2;
    do_reset();
    cnt = 0;
    for (int k = 1; k <= 23; k++) begin
      if (k > 1) go();
      if (k <= 20) cnt += int'(bclk | lrclk);
      if (k == 20) master = 1;
      if (k == 22) check(bclk == 1'b0, "R10 bclk before first rise", int'(bclk), 0);
      if (k == 23) check(bclk == 1'b1, "R10 bclk restart rise", int'(bclk), 1);
    end
    check(cnt == 0, "R10 slave clocks active", cnt, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule